// File: doc/BRIEF.md
# Transmit Pause Arbiter and Timer

This block decides what the transmit path of a 64-bit, eight-octets-per-clock Ethernet MAC does next. Three sources compete for it. The first is a pause duration, in quanta, decoded from a received flow-control frame. The second is a local request to send a pause frame. The third is a user data frame waiting to go out. When a received pause is in effect, the block raises an idle-force flag. While that flag is high, the formatter downstream drives IDLE (control code 0x07) on every lane.

One quanta equals 512 bit times, which is 64 octets. With eight octets per clock, that is eight clock cycles. A received pause outranks both kinds of frame, but it never cuts into a frame that has already been granted. A pause that arrives during a frame waits until the frame's last beat and then runs in full. Each new valid quanta strobe replaces the pause value, whether that pause is running or waiting, and restarts the count. A quanta of zero clears the pause at once.

Between consecutive frames the block holds back new grants for a programmable inter-packet gap, counted in clock cycles. The idle-force flag serves as the grant for the received-pause source. Each frame source has its own grant, which stays high from the frame's first beat until its last.

Top module: `tx_pause_arb`

## Requirements
- R1: After reset, `grant_pfrm`, `grant_data` and `idle_force` are all low.
- R2: A strobe with a non-zero quanta Q, taken while no frame is granted, raises `idle_force` in the next cycle. The flag then stays high for exactly 8*Q consecutive cycles.
- R3: No grant is raised while `idle_force` is high. A non-zero quanta strobe in the same cycle as a request on a free path blocks that request's grant.
- R4: A quanta strobe that arrives while a frame is granted does not raise `idle_force` during the frame. The pause starts in the cycle after the `frame_done` cycle and lasts the full 8*Q cycles.
- R5: A new non-zero strobe during an active pause reloads the count, so that `idle_force` stays high for exactly 8*Q' further cycles, where Q' is the new quanta.
- R6: A strobe with quanta 0 forces `idle_force` low from the next cycle. This applies both to an active pause and to a pause queued behind a frame.
- R7: When both `pfrm_req` and `data_ready` are high on a free path, the pause-frame request wins: `grant_pfrm` rises and `grant_data` stays low.
- R8: After a `frame_done` beat, with a request waiting and no pause, both grants stay low for exactly `ipg_cycles`+1 cycles.
- R9: A grant stays high from its first cycle through the cycle in which `frame_done` is high. A `frame_done` pulse while no grant is high is ignored and loads no gap.
- R10: At most one of `grant_pfrm`, `grant_data` and `idle_force` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxq_valid | input | 1 | One-cycle strobe: a received pause quanta passed its CRC check |
| rxq_value | input | QUANTA_W | Pause duration in 512-bit-time quanta |
| pfrm_req | input | 1 | Local pause-frame transmit request, held until granted |
| data_ready | input | 1 | A user data frame is waiting |
| frame_done | input | 1 | Last beat of the granted frame |
| ipg_cycles | input | IPG_W | Inter-packet gap in clock cycles (pseudo-static) |
| grant_pfrm | output | 1 | Pause-frame source owns the transmit path |
| grant_data | output | 1 | Data-frame source owns the transmit path |
| idle_force | output | 1 | Received pause in effect: transmit IDLE |

## Verification
The bench builds the block with a 4-bit quanta field and a 3-bit gap field. With these widths, every quanta value from 0 to 15 can be swept, and every gap from 0 to 7 can be measured against the ipg+1 rule. Pause lengths can be counted exactly while a data request is held pending. Directed sequences cover the orderings that matter most: a pause queued behind a frame, a reload during a pause, a zero cancel of both an active and a queued pause, simultaneous requests, and a stray `frame_done` on an idle path.

// File: rtl/tpa_pkg.sv
// Package: shared definitions for the transmit pause arbiter.
// Assumes: a single transmit path with at most one owner at a time.
package tpa_pkg;

    // Owner of the transmit path while a frame is in flight.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PFRM = 2'd1,
        SRC_DATA = 2'd2
    } tpa_src_e;

    // Octets carried by one quanta (512 bit times).
    localparam int unsigned OCTETS_PER_QUANTA = 64;

endpackage

// File: rtl/tpa_pause_timer.sv
// Module: tpa_pause_timer
// Holds the received pause as a count of clock cycles. Each strobe loads
// quanta * (cycles per quanta), which overwrites any value already held; a
// quanta of zero clears the count. The count decrements only while no
// frame holds the path, so a pause that arrives mid-frame waits in place.
// Assumes: BYTES_PER_CYCLE is a power of two that divides 64.
module tpa_pause_timer #(
    parameter int unsigned QUANTA_W        = 16,
    parameter int unsigned BYTES_PER_CYCLE = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [QUANTA_W-1:0] load_quanta,
    input  logic                hold,
    output logic                active
);
    localparam int unsigned CYC_PER_Q = tpa_pkg::OCTETS_PER_QUANTA / BYTES_PER_CYCLE;
    localparam int unsigned Q_SHIFT   = $clog2(CYC_PER_Q);
    localparam int unsigned CNT_W     = QUANTA_W + Q_SHIFT;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] load_cycles;

    // Scale quanta to cycles; a wide datapath may need no scaling.
    generate
        if (Q_SHIFT == 0) begin : g_noscale
            assign load_cycles = load_quanta;
        end else begin : g_scale
            assign load_cycles = {load_quanta, {Q_SHIFT{1'b0}}};
        end
    endgenerate

    assign active = (cnt_q != '0);

    // Next count: a strobe overwrites, otherwise decrement while the path is free.
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_cycles;
        end else if (active && !hold) begin
            cnt_d = cnt_q - CNT_ONE;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/tpa_gap_timer.sv
// Module: tpa_gap_timer
// Counts the inter-packet gap after each frame. It loads the programmed
// gap on the last beat of a frame and counts down to zero. While it is
// non-zero, no new frame may be granted.
// Assumes: the gap value is pseudo-static while the block runs.
module tpa_gap_timer #(
    parameter int unsigned IPG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IPG_W-1:0] gap,
    output logic             busy
);
    localparam logic [IPG_W-1:0] GAP_ONE = IPG_W'(1);

    logic [IPG_W-1:0] gcnt_q;
    logic [IPG_W-1:0] gcnt_d;

    assign busy = (gcnt_q != '0);

    // Next gap count: load at frame end, otherwise run down to zero.
    always_comb begin
        gcnt_d = gcnt_q;
        if (load) begin
            gcnt_d = gap;
        end else if (busy) begin
            gcnt_d = gcnt_q - GAP_ONE;
        end
    end

    // Gap register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt_q <= '0;
        end else begin
            gcnt_q <= gcnt_d;
        end
    end

endmodule

// File: rtl/tpa_frame_arb.sv
// Module: tpa_frame_arb
// Grants the transmit path to one frame source at a time. The pause-frame
// request outranks data. A grant is taken only while the path is free and
// not blocked, and it is held until the frame's last beat.
// Assumes: requesters hold their request until granted; frame_done is
// only meaningful while a grant is held.
module tpa_frame_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic req_pfrm,
    input  logic req_data,
    input  logic blocked,
    input  logic frame_done,
    output logic grant_pfrm,
    output logic grant_data,
    output logic in_frame,
    output logic frame_end
);
    import tpa_pkg::*;

    tpa_src_e src_q;
    tpa_src_e src_d;
    logic     start;

    assign in_frame  = (src_q != SRC_NONE);
    assign frame_end = in_frame && frame_done;
    assign start     = !in_frame && !blocked && (req_pfrm || req_data);

    // Choose the next owner: release on the last beat, grant by fixed priority.
    always_comb begin
        src_d = src_q;
        if (frame_end) begin
            src_d = SRC_NONE;
        end else if (start) begin
            src_d = req_pfrm ? SRC_PFRM : SRC_DATA;
        end
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_NONE;
        end else begin
            src_q <= src_d;
        end
    end

    assign grant_pfrm = (src_q == SRC_PFRM);
    assign grant_data = (src_q == SRC_DATA);

endmodule

// File: rtl/tx_pause_arb.sv
// Module: tx_pause_arb (top)
// Arbitrates the transmit path among a received pause, a local pause-frame
// request and user data. A received pause blocks new grants and drives
// idle_force while no frame holds the path. The gap timer enforces the
// inter-packet gap after every frame.
// Assumes: rxq_valid is a one-cycle strobe for each CRC-checked pause frame.
module tx_pause_arb #(
    parameter int unsigned QUANTA_W        = 16,
    parameter int unsigned IPG_W           = 4,
    parameter int unsigned BYTES_PER_CYCLE = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rxq_valid,
    input  logic [QUANTA_W-1:0] rxq_value,
    input  logic                pfrm_req,
    input  logic                data_ready,
    input  logic                frame_done,
    input  logic [IPG_W-1:0]    ipg_cycles,
    output logic                grant_pfrm,
    output logic                grant_data,
    output logic                idle_force
);
    logic pause_active;
    logic gap_busy;
    logic in_frame;
    logic frame_end;
    logic pause_arriving;
    logic blocked;

    // A non-zero strobe this cycle already outranks any frame request.
    assign pause_arriving = rxq_valid && (rxq_value != '0);
    assign blocked        = pause_active || gap_busy || pause_arriving;

    tpa_pause_timer #(
        .QUANTA_W       (QUANTA_W),
        .BYTES_PER_CYCLE(BYTES_PER_CYCLE)
    ) u_pause (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (rxq_valid),
        .load_quanta(rxq_value),
        .hold       (in_frame),
        .active     (pause_active)
    );

    tpa_gap_timer #(
        .IPG_W(IPG_W)
    ) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .load (frame_end),
        .gap  (ipg_cycles),
        .busy (gap_busy)
    );

    tpa_frame_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pfrm  (pfrm_req),
        .req_data  (data_ready),
        .blocked   (blocked),
        .frame_done(frame_done),
        .grant_pfrm(grant_pfrm),
        .grant_data(grant_data),
        .in_frame  (in_frame),
        .frame_end (frame_end)
    );

    // The pause takes effect only while no frame holds the path.
    assign idle_force = pause_active && !in_frame;

endmodule

// File: rtl/tx_pause_arb_chk.sv
// Module: tx_pause_arb_chk
// Checker bound to tx_pause_arb. It observes only the ports.
module tx_pause_arb_chk #(
    parameter int unsigned QUANTA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rxq_valid,
    input logic [QUANTA_W-1:0] rxq_value,
    input logic                frame_done,
    input logic                grant_pfrm,
    input logic                grant_data,
    input logic                idle_force
);
    // R10
    owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_pfrm, grant_data, idle_force}));

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_data && !frame_done) |=> grant_data);

    // R9
    pfrm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_pfrm && !frame_done) |=> grant_pfrm);

    // R3
    no_grant_in_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_force |=> !(grant_pfrm || grant_data));

    // R6
    zero_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxq_valid && rxq_value == '0) |=> !idle_force);

    // R2
    pause_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxq_valid && rxq_value != '0 && !grant_pfrm && !grant_data) |=> idle_force);

    // R8
    gap_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_pfrm || grant_data) && frame_done) |=> !(grant_pfrm || grant_data));

endmodule

bind tx_pause_arb tx_pause_arb_chk #(.QUANTA_W(QUANTA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxq_valid (rxq_valid),
    .rxq_value (rxq_value),
    .frame_done(frame_done),
    .grant_pfrm(grant_pfrm),
    .grant_data(grant_data),
    .idle_force(idle_force)
);

// File: tb/tx_pause_arb_tb.sv
`timescale 1ns/1ps
module tx_pause_arb_tb;
    localparam int QW = 4;
    localparam int GW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxq_valid = 1'b0;
    logic [QW-1:0] rxq_value = '0;
    logic          pfrm_req = 1'b0;
    logic          data_ready = 1'b0;
    logic          frame_done = 1'b0;
    logic [GW-1:0] ipg_cycles = '0;
    logic          grant_pfrm, grant_data, idle_force;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tx_pause_arb #(.QUANTA_W(QW), .IPG_W(GW), .BYTES_PER_CYCLE(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .rxq_valid(rxq_valid), .rxq_value(rxq_value),
        .pfrm_req(pfrm_req), .data_ready(data_ready), .frame_done(frame_done),
        .ipg_cycles(ipg_cycles), .grant_pfrm(grant_pfrm), .grant_data(grant_data),
        .idle_force(idle_force)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe one quanta value for one cycle, driven at the falling edge.
    task automatic strobe(input int q);
        rxq_valid = 1'b1;
        rxq_value = QW'(q);
        @(negedge clk);
        rxq_valid = 1'b0;
    endtask

    // Count consecutive idle_force cycles; also counts grants seen meanwhile.
    task automatic count_idle(output int n, output int g);
        n = 0; g = 0;
        while (idle_force && n < 400) begin
            n++;
            if (grant_pfrm || grant_data) g++;
            @(negedge clk);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // End the frame currently granted.
    task automatic end_frame();
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n, g, lo, hi;
        wait_cycles(3);
        // R1 reset state
        chk(!grant_pfrm && !grant_data && !idle_force, "R1 reset",
            {grant_pfrm, grant_data, idle_force}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!grant_pfrm && !grant_data && !idle_force, "R1 after release",
            {grant_pfrm, grant_data, idle_force}, 0);

        // R2 sweep every quanta value, pause length is 8*Q
        for (int q = 0; q < 16; q++) begin
            strobe(q);
            count_idle(n, g);
            chk(n == 8 * q, "R2 pause length", n, 8 * q);
            wait_cycles(2);
        end

        // R3 pause strobe together with a data request blocks the grant
        ipg_cycles = '0;
        data_ready = 1'b1;
        strobe(1);
        chk(!grant_data && idle_force, "R3 same-cycle block", grant_data, 0);
        count_idle(n, g);
        chk(g == 0, "R3 no grant during pause", g, 0);
        chk(n == 8, "R3 pause length with request", n, 8);
        @(negedge clk);
        chk(grant_data, "R3 grant after pause", grant_data, 1);
        data_ready = 1'b0;
        end_frame();
        wait_cycles(10);

        // R4 pause queued behind a data frame
        data_ready = 1'b1;
        @(negedge clk);
        chk(grant_data, "R4 frame granted", grant_data, 1);
        data_ready = 1'b0;
        strobe(2);
        chk(!idle_force && grant_data, "R4 no idle during frame", idle_force, 0);
        end_frame();
        count_idle(n, g);
        chk(n == 16, "R4 queued pause length", n, 16);
        wait_cycles(10);

        // R5 reload during an active pause
        strobe(5);
        wait_cycles(10);
        chk(idle_force, "R5 pause running", idle_force, 1);
        strobe(2);
        count_idle(n, g);
        chk(n == 16, "R5 reload length", n, 16);
        wait_cycles(4);

        // R6 zero cancels an active pause
        strobe(5);
        wait_cycles(3);
        strobe(0);
        lo = 0;
        for (int i = 0; i < 6; i++) begin
            if (idle_force) lo++;
            @(negedge clk);
        end
        chk(lo == 0, "R6 cancel active", lo, 0);

        // R6 zero cancels a pause queued behind a frame
        data_ready = 1'b1;
        @(negedge clk);
        data_ready = 1'b0;
        strobe(3);
        strobe(0);
        end_frame();
        lo = 0;
        for (int i = 0; i < 30; i++) begin
            if (idle_force) lo++;
            @(negedge clk);
        end
        chk(lo == 0, "R6 cancel queued", lo, 0);

        // R7 pause-frame request outranks data
        ipg_cycles = 3'd2;
        pfrm_req = 1'b1;
        data_ready = 1'b1;
        @(negedge clk);
        chk(grant_pfrm && !grant_data, "R7 priority", {grant_pfrm, grant_data}, 2);
        pfrm_req = 1'b0;
        end_frame();
        wait_cycles(3);
        chk(grant_data, "R7 data after pause frame", grant_data, 1);
        data_ready = 1'b0;
        end_frame();
        wait_cycles(10);

        // R8/R9 sweep every gap value with back-to-back 3-beat frames
        for (int gv = 0; gv < 8; gv++) begin
            ipg_cycles = GW'(gv);
            data_ready = 1'b1;
            while (!grant_data) @(negedge clk);
            hi = 0;
            while (grant_data && hi < 3) begin
                hi++;
                if (hi == 3) frame_done = 1'b1;
                @(negedge clk);
            end
            frame_done = 1'b0;
            chk(hi == 3, "R9 grant held to last beat", hi, 3);
            lo = 0;
            while (!grant_data && lo < 40) begin
                lo++;
                @(negedge clk);
            end
            chk(lo == gv + 1, "R8 gap length", lo, gv + 1);
            data_ready = 1'b0;
            end_frame();
            wait_cycles(10);
        end

        // R9 stray frame_done while idle loads no gap
        ipg_cycles = 3'd7;
        end_frame();
        data_ready = 1'b1;
        @(negedge clk);
        chk(grant_data, "R9 stray done ignored", grant_data, 1);
        data_ready = 1'b0;
        end_frame();
        wait_cycles(10);

        // R10 simultaneous everything: only one owner
        pfrm_req = 1'b1;
        data_ready = 1'b1;
        strobe(1);
        chk({grant_pfrm, grant_data, idle_force} == 3'b001, "R10 single owner",
            {grant_pfrm, grant_data, idle_force}, 1);
        count_idle(n, g);
        @(negedge clk);
        chk(grant_pfrm && !grant_data, "R10 pause frame after pause",
            {grant_pfrm, grant_data}, 2);
        pfrm_req = 1'b0;
        data_ready = 1'b0;
        end_frame();
        wait_cycles(10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule